// File: doc/BRIEF.md
# Processor Bus Cycle Classifier

This block watches the control strobes, the 16-bit address bus and the 8-bit data bus of an 8-bit microprocessor without driving any of them. All bus inputs pass through a chain of synchronizing flip-flops into the sampling clock domain. Each synchronized sample is then sorted into one of seven cycle kinds: idle, memory read, memory write, I/O read, I/O write, opcode fetch or interrupt acknowledge.

The block marks the beginning of every bus cycle with a one-clock pulse and the address seen on that first sample. It marks the end with a one-clock pulse that carries the kind of cycle that finished, the class under which its data is reported, and the last data byte seen while the cycle was active. A direct change from one active kind to a different one, with no idle sample between them, gives a warning pulse and discards the address of the cycle in progress.

Top module: `bus_cycle_sorter`

## Requirements
- R1: After reset, and after a reset applied in the middle of a cycle, `cur_kind` is 0 and `cyc_start`, `cyc_end` and `bad_switch` are low. Releasing reset with idle strobes produces no pulse.
- R2: With the memory strobe low and the read strobe low, the kind is 5 (opcode fetch) if the first-cycle strobe is low, and 1 (memory read) otherwise. With the memory strobe low, read high and write low, the kind is 2 (memory write).
- R3: With the memory strobe high and the I/O strobe low, the kind is 6 (interrupt acknowledge) if the first-cycle strobe is low. Otherwise it is 3 (I/O read) if read is low, or 4 (I/O write) if write is low. When both the memory and I/O strobes are low, the memory rules decide.
- R4: Every other strobe pattern is kind 0 (idle). This includes memory strobe low with read and write both high.
- R5: `cyc_start` pulses for one clock on the first active sample that follows an idle sample, and `start_addr` takes the address of that sample. A change at the pins reaches the registered outputs on the third rising clock edge (two synchronizer stages plus one output register).
- R6: `cyc_end` pulses for one clock on the first idle sample after an active one. On that pulse, `end_kind` gives the kind that ended and `end_data` gives the data byte of the last active sample.
- R7: `end_class` is the kind under which the ended cycle's data is reported. It equals `end_kind` for kinds 1 to 4, is 1 for an opcode fetch, and is 3 for an interrupt acknowledge.
- R8: A sample whose active kind differs from the preceding active kind gives a one-clock `bad_switch` pulse and no `cyc_start`. `end_addr_ok` is then 0 when that cycle ends, and 1 for cycles that started from idle and did not switch.
- R9: Address changes after the first active sample do not change `start_addr`. Neither does a continuing sample of the same kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| first_n | input | 1 | First-machine-cycle strobe, active low |
| read_n | input | 1 | Read strobe, active low |
| write_n | input | 1 | Write strobe, active low |
| mem_n | input | 1 | Memory request strobe, active low |
| io_n | input | 1 | I/O request strobe, active low |
| addr_in | input | ADDR_W | Address bus |
| data_in | input | DATA_W | Data bus |
| cur_kind | output | 3 | Kind of the most recent classified sample |
| cyc_start | output | 1 | One-clock pulse at the start of a cycle |
| start_addr | output | ADDR_W | Address captured at the last cycle start |
| cyc_end | output | 1 | One-clock pulse at the end of a cycle |
| end_kind | output | 3 | Kind of the cycle that ended |
| end_class | output | 3 | Data report class of the ended cycle |
| end_data | output | DATA_W | Last data byte of the ended cycle |
| end_addr_ok | output | 1 | Ended cycle kept its start address |
| bad_switch | output | 1 | One-clock pulse on an active-to-active change |

## Verification
The assertions assume the strobes hold steady for at least one sampling clock, so that the synchronized stream is a clean sequence of samples. They also assume reset lasts at least as many clocks as there are synchronizer stages. The stimulus changes the bus only just after a falling clock edge, holds each pattern for five clocks, and returns to an all-high idle pattern between most cycles. One step switches kinds directly on purpose, to exercise the warning path.

// File: rtl/bus_cycle_sorter.sv
module bus_cycle_sorter #(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              first_n,
  input  logic              read_n,
  input  logic              write_n,
  input  logic              mem_n,
  input  logic              io_n,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  output logic [2:0]        cur_kind,
  output logic              cyc_start,
  output logic [ADDR_W-1:0] start_addr,
  output logic              cyc_end,
  output logic [2:0]        end_kind,
  output logic [2:0]        end_class,
  output logic [DATA_W-1:0] end_data,
  output logic              end_addr_ok,
  output logic              bad_switch
);
  localparam int STRB_W = 5;
  localparam int VEC_W  = STRB_W + ADDR_W + DATA_W;
  localparam logic [VEC_W-1:0] IDLE_VEC = {{STRB_W{1'b1}}, {(ADDR_W + DATA_W){1'b0}}};

  localparam logic [2:0] K_NONE  = 3'd0;
  localparam logic [2:0] K_MRD   = 3'd1;
  localparam logic [2:0] K_MWR   = 3'd2;
  localparam logic [2:0] K_IORD  = 3'd3;
  localparam logic [2:0] K_IOWR  = 3'd4;
  localparam logic [2:0] K_FETCH = 3'd5;
  localparam logic [2:0] K_IACK  = 3'd6;

  logic [VEC_W-1:0] pipe [SYNC_STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < SYNC_STAGES; i++) pipe[i] <= IDLE_VEC;
    end else begin
      pipe[0] <= {first_n, read_n, write_n, mem_n, io_n, addr_in, data_in};
      for (int i = 1; i < SYNC_STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  logic              s_first, s_read, s_write, s_mem, s_io;
  logic [ADDR_W-1:0] s_addr;
  logic [DATA_W-1:0] s_data;
  assign {s_first, s_read, s_write, s_mem, s_io, s_addr, s_data} = pipe[SYNC_STAGES-1];

  logic [2:0] mem_kind, io_kind, kind;
  assign mem_kind = !s_read  ? (!s_first ? K_FETCH : K_MRD) :
                    !s_write ? K_MWR : K_NONE;
  assign io_kind  = !s_first ? K_IACK :
                    !s_read  ? K_IORD :
                    !s_write ? K_IOWR : K_NONE;
  assign kind     = !s_mem ? mem_kind : (!s_io ? io_kind : K_NONE);

  logic was_idle, now_idle;
  assign was_idle = (cur_kind == K_NONE);
  assign now_idle = (kind == K_NONE);

  function automatic logic [2:0] report_class(input logic [2:0] k);
    case (k)
      K_FETCH: report_class = K_MRD;
      K_IACK:  report_class = K_IORD;
      default: report_class = k;
    endcase
  endfunction

  logic [DATA_W-1:0] data_hold;
  logic              addr_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_kind    <= K_NONE;
      cyc_start   <= 1'b0;
      cyc_end     <= 1'b0;
      bad_switch  <= 1'b0;
      start_addr  <= '0;
      end_kind    <= K_NONE;
      end_class   <= K_NONE;
      end_data    <= '0;
      end_addr_ok <= 1'b0;
      addr_ok     <= 1'b0;
      data_hold   <= '0;
    end else begin
      cur_kind   <= kind;
      cyc_start  <= was_idle && !now_idle;
      cyc_end    <= !was_idle && now_idle;
      bad_switch <= !was_idle && !now_idle && (kind != cur_kind);
      if (!now_idle) data_hold <= s_data;
      if (was_idle && !now_idle) begin
        start_addr <= s_addr;
        addr_ok    <= 1'b1;
      end else if (!was_idle && !now_idle && (kind != cur_kind)) begin
        addr_ok <= 1'b0;
      end
      if (!was_idle && now_idle) begin
        end_kind    <= cur_kind;
        end_class   <= report_class(cur_kind);
        end_data    <= data_hold;
        end_addr_ok <= addr_ok;
      end
    end
  end

  assert_start_from_idle_R5: assert property (@(posedge clk) disable iff (rst)
    cyc_start |-> (cur_kind != K_NONE) && ($past(cur_kind) == K_NONE));

  assert_end_to_idle_R6: assert property (@(posedge clk) disable iff (rst)
    cyc_end |-> (cur_kind == K_NONE) && ($past(cur_kind) != K_NONE));

  assert_switch_between_active_R8: assert property (@(posedge clk) disable iff (rst)
    bad_switch |-> (cur_kind != K_NONE) && ($past(cur_kind) != K_NONE)
                   && (cur_kind != $past(cur_kind)));

  assert_single_event_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cyc_start, cyc_end, bad_switch}));

  assert_end_class_range_R7: assert property (@(posedge clk) disable iff (rst)
    cyc_end |-> (end_class >= K_MRD) && (end_class <= K_IOWR));

  assert_end_one_clock_R6: assert property (@(posedge clk) disable iff (rst)
    cyc_end |=> !cyc_end);

  assert_addr_held_R9: assert property (@(posedge clk) disable iff (rst)
    !cyc_start |-> $stable(start_addr));
endmodule

// File: tb/test_bus_cycle_sorter.sv
module test_bus_cycle_sorter;
  localparam int CLK_NS = 10;
  localparam int HOLD   = 5;
  localparam int NSTEP  = 22;

  typedef struct packed {
    logic [4:0]  ctrl;
    logic [15:0] addr;
    logic [7:0]  data;
    logic [2:0]  kind;
    logic        st;
    logic        en;
    logic        bad;
    logic [2:0]  cls;
    logic [2:0]  ekd;
    logic [7:0]  edat;
    logic        ok;
    logic [15:0] saddr;
  } step_t;

  // ctrl = {first_n, read_n, write_n, mem_n, io_n}
  localparam step_t STEPS [NSTEP] = '{
    '{5'b11111, 16'h0000, 8'h00, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 16'h0000},
    '{5'b00101, 16'h1234, 8'h3E, 3'd5, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 16'h1234},
    '{5'b11111, 16'h1234, 8'hAA, 3'd0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd5, 8'h3E, 1'b1, 16'h1234},
    '{5'b10101, 16'h4000, 8'h11, 3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 16'h4000},
    '{5'b11111, 16'h4000, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd1, 8'h11, 1'b1, 16'h4000},
    '{5'b11001, 16'h8001, 8'h22, 3'd2, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 16'h8001},
    '{5'b11111, 16'h8001, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 3'd2, 3'd2, 8'h22, 1'b1, 16'h8001},
    '{5'b10110, 16'h00FE, 8'h33, 3'd3, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 16'h00FE},
    '{5'b11111, 16'h00FE, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 3'd3, 3'd3, 8'h33, 1'b1, 16'h00FE},
    '{5'b11010, 16'h0042, 8'h44, 3'd4, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 16'h0042},
    '{5'b11111, 16'h0042, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 3'd4, 3'd4, 8'h44, 1'b1, 16'h0042},
    '{5'b01110, 16'h0038, 8'hFF, 3'd6, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 16'h0038},
    '{5'b11111, 16'h0038, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 3'd3, 3'd6, 8'hFF, 1'b1, 16'h0038},
    '{5'b11101, 16'h5555, 8'h77, 3'd0, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 16'h0038},
    '{5'b10100, 16'h6000, 8'h55, 3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 16'h6000},
    '{5'b11111, 16'h6000, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd1, 8'h55, 1'b1, 16'h6000},
    '{5'b10101, 16'h1111, 8'h01, 3'd1, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 16'h1111},
    '{5'b10101, 16'h2222, 8'h02, 3'd1, 1'b0, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 16'h1111},
    '{5'b11001, 16'h3333, 8'h03, 3'd2, 1'b0, 1'b0, 1'b1, 3'd0, 3'd0, 8'h00, 1'b0, 16'h1111},
    '{5'b11111, 16'h3333, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 3'd2, 3'd2, 8'h03, 1'b0, 16'h1111},
    '{5'b00101, 16'hABCD, 8'hC9, 3'd5, 1'b1, 1'b0, 1'b0, 3'd0, 3'd0, 8'h00, 1'b0, 16'hABCD},
    '{5'b11111, 16'hABCD, 8'h00, 3'd0, 1'b0, 1'b1, 1'b0, 3'd1, 3'd5, 8'hC9, 1'b1, 16'hABCD}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        first_n = 1'b1, read_n = 1'b1, write_n = 1'b1, mem_n = 1'b1, io_n = 1'b1;
  logic [15:0] addr_in = '0;
  logic [7:0]  data_in = '0;
  logic [2:0]  cur_kind, end_kind, end_class;
  logic        cyc_start, cyc_end, end_addr_ok, bad_switch;
  logic [15:0] start_addr;
  logic [7:0]  end_data;

  bus_cycle_sorter i_bus_cycle_sorter (
    .clk(clk), .rst(rst),
    .first_n(first_n), .read_n(read_n), .write_n(write_n), .mem_n(mem_n), .io_n(io_n),
    .addr_in(addr_in), .data_in(data_in),
    .cur_kind(cur_kind), .cyc_start(cyc_start), .start_addr(start_addr),
    .cyc_end(cyc_end), .end_kind(end_kind), .end_class(end_class),
    .end_data(end_data), .end_addr_ok(end_addr_ok), .bad_switch(bad_switch)
  );

  always #(CLK_NS/2) clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;
  int n_start = 0, n_end = 0, n_bad = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (cyc_start)  n_start++;
      if (cyc_end)    n_end++;
      if (bad_switch) n_bad++;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic drive(input logic [4:0] c, input logic [15:0] a, input logic [7:0] d);
    {first_n, read_n, write_n, mem_n, io_n} = c;
    addr_in = a;
    data_in = d;
  endtask

  initial begin
    #(CLK_NS * 20000);
    total++;
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R1: state after reset
    chk("R1 kind", cur_kind, 0);
    chk("R1 pulses", {cyc_start, cyc_end, bad_switch}, 0);

    for (int s = 0; s < NSTEP; s++) begin
      int s0, e0, b0;
      @(negedge clk); #1;
      drive(STEPS[s].ctrl, STEPS[s].addr, STEPS[s].data);
      s0 = n_start; e0 = n_end; b0 = n_bad;
      repeat (HOLD) @(negedge clk);
      #1;
      chk($sformatf("R2/R3/R4 kind step %0d", s), cur_kind, STEPS[s].kind);
      chk($sformatf("R5 start count step %0d", s), n_start - s0, STEPS[s].st);
      chk($sformatf("R6 end count step %0d", s), n_end - e0, STEPS[s].en);
      chk($sformatf("R8 switch count step %0d", s), n_bad - b0, STEPS[s].bad);
      chk($sformatf("R9 start_addr step %0d", s), start_addr, STEPS[s].saddr);
      if (STEPS[s].en) begin
        chk($sformatf("R6 end_kind step %0d", s), end_kind, STEPS[s].ekd);
        chk($sformatf("R6 end_data step %0d", s), end_data, STEPS[s].edat);
        chk($sformatf("R7 end_class step %0d", s), end_class, STEPS[s].cls);
        chk($sformatf("R8 end_addr_ok step %0d", s), end_addr_ok, STEPS[s].ok);
      end
    end

    // R5: latency of three rising edges from pin change to start pulse
    @(negedge clk); #1;
    drive(5'b10101, 16'h7777, 8'h5A);
    @(negedge clk); #1;
    chk("R5 latency edge1", cyc_start, 0);
    @(negedge clk); #1;
    chk("R5 latency edge2", cyc_start, 0);
    @(negedge clk); #1;
    chk("R5 latency edge3", cyc_start, 1);
    chk("R5 latency addr", start_addr, 16'h7777);
    @(negedge clk); #1;
    chk("R5 one clock", cyc_start, 0);

    // R1: reset in the middle of an active cycle
    rst = 1'b1;
    drive(5'b11111, 16'h0000, 8'h00);
    repeat (3) @(negedge clk); #1;
    chk("R1 mid reset kind", cur_kind, 0);
    chk("R1 mid reset addr", start_addr, 0);
    rst = 1'b0;
    begin
      int e0, s0;
      e0 = n_end; s0 = n_start;
      repeat (HOLD) @(negedge clk); #1;
      chk("R1 no end after reset", n_end - e0, 0);
      chk("R1 no start after reset", n_start - s0, 0);
      chk("R1 kind idle", cur_kind, 0);
    end
    finish_run();
  end
endmodule